// File: doc/BRIEF.md
# Pixel Port Unpacking Multiplexer

The block sits between a frame-buffer interface and a colour palette. A load strobe captures either the 16-bit pixel bus or the 8-bit legacy VGA bus as a single word in one clock. That word is then split into 8-bit groups and sent out one group per pixel clock. The lowest-numbered group goes first. Each output group is a palette address, and a valid flag marks it.

Software programs two settings through a small write port. The first is a mode register, which selects the source bus and how the word is packed. The second is a separate pixels-per-load register, which sets how many groups each load releases. Writing one of these registers never changes the other.

A width-select input chooses between full 8-bit output and 6-bit output, and it applies in every mode. After reset the block is in pass-through mode, which takes one pixel per load from the VGA bus.

Top module: `pix_unpack_mux`

## Requirements
- R1: Reset (synchronous, active high) sets the mode to pass-through (mode value 2Dh) and the pixels-per-load count to 1. It also clears the valid flag and forces the pixel output to zero.
- R2: Mode bits [5:0] = 101101 select pass-through. The group-0 pixel is the VGA bus, and any higher group reads as zero. Mode bits [7:6] are ignored, so writing 9Dh acts exactly like 1Dh.
- R3: Mode bits [5:0] = 011100 select single-pixel mode. The group-0 pixel is pixel bus bits [7:0], and any higher group reads as zero.
- R4: Mode bits [5:0] = 011101 select two-pixel mode. Pixel bus bits [7:0] come out first, and bits [15:8] come out on the next pixel clock.
- R5: The pixels-per-load register is written at configuration address 1, and the mode register at address 0. A mode write leaves the count unchanged. Writing 0 stores 1, and any value above the group count (2) stores 2.
- R6: A load strobe sampled at clock edge k makes group 0 visible with valid high after edge k. The valid flag then stays high for exactly the programmed count of consecutive cycles, and drops afterwards.
- R7: A load that arrives while groups are still pending discards them. Output restarts from group 0 of the new word on the next cycle.
- R8: With the width select low, each output group is the low 6 bits of its pixel, with bits [7:6] zero. With it high, all 8 bits pass. The select is sampled separately for every group.
- R9: Any undefined mode encoding behaves as pass-through.
- R10: Without a load, the valid flag never rises. While valid is low, the pixel output is zero.
- R11: A configuration write and a load in the same cycle use the register contents from before the write. The new value applies from the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 1 | 0 = mode register, 1 = pixels-per-load register |
| cfg_wdata | input | 8 | Configuration write data |
| load_stb | input | 1 | Single-cycle word load strobe |
| pix_bus | input | 16 | Packed pixel bus |
| vga_bus | input | 8 | Legacy VGA pixel bus |
| width8_sel | input | 1 | 1 = 8-bit output, 0 = 6-bit output |
| pix_out | output | 8 | Palette address output |
| pix_valid | output | 1 | High for each shifted group |

## Verification
Two functions can fall in the same cycle: a fresh load and the shift of a pending group. The bench provokes this by raising the strobe again right after the first group of a two-pixel word. It passes only if the next outputs are the new word's groups 0 and 1 and no stale group appears. The bench also lines up a mode write with a load in the same cycle, and judges that case by whether the old or the new mode shaped the burst.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  typedef enum logic [1:0] {
    SRC_VGA  = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_WIDE = 2'd2
  } src_e;

  localparam logic [5:0] CODE_PASS   = 6'b101101;
  localparam logic [5:0] CODE_SINGLE = 6'b011100;
  localparam logic [5:0] CODE_DUAL   = 6'b011101;

  localparam logic [7:0] MODE_RESET  = 8'h2D;

  // Undefined encodings collapse onto the VGA source.
  function automatic src_e decode_mode(input logic [5:0] code);
    case (code)
      CODE_SINGLE: decode_mode = SRC_LOW;
      CODE_DUAL:   decode_mode = SRC_WIDE;
      default:     decode_mode = SRC_VGA;
    endcase
  endfunction

endpackage

// File: rtl/pix_cfg_regs.sv
module pix_cfg_regs
  import pix_unpack_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int CFG_W  = 8,
  localparam int CNT_W = $clog2(GROUPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [5:0]       mode_code,
  output logic [CNT_W-1:0] grp_count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_code <= MODE_RESET[5:0];
      grp_count <= CNT_W'(1);
    end else if (cfg_we) begin
      if (!cfg_addr) begin
        // Upper two mode bits carry no meaning and are not stored.
        mode_code <= cfg_wdata[5:0];
      end else if (cfg_wdata == '0) begin
        grp_count <= CNT_W'(1);
      end else if (int'(cfg_wdata) > GROUPS) begin
        grp_count <= CNT_W'(GROUPS);
      end else begin
        grp_count <= cfg_wdata[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pix_src_select.sv
module pix_src_select
  import pix_unpack_pkg::*;
#(
  parameter int GRP_W  = 8,
  parameter int GROUPS = 2,
  localparam int WORD_W = GRP_W * GROUPS
) (
  input  logic [5:0]        mode_code,
  input  logic [WORD_W-1:0] pix_bus,
  input  logic [GRP_W-1:0]  vga_bus,
  output logic [WORD_W-1:0] word
);

  src_e src;

  always_comb begin
    src  = decode_mode(mode_code);
    word = '0;
    case (src)
      SRC_WIDE: word = pix_bus;
      SRC_LOW:  word[GRP_W-1:0] = pix_bus[GRP_W-1:0];
      default:  word[GRP_W-1:0] = vga_bus;
    endcase
  end

endmodule

// File: rtl/pix_shift_unit.sv
module pix_shift_unit #(
  parameter int GRP_W    = 8,
  parameter int GROUPS   = 2,
  parameter int NARROW_W = 6,
  localparam int WORD_W  = GRP_W * GROUPS,
  localparam int CNT_W   = $clog2(GROUPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  grp_count,
  input  logic              width8_sel,
  output logic [GRP_W-1:0]  pix_out,
  output logic              pix_valid
);

  localparam logic [GRP_W-1:0] NARROW_MASK = GRP_W'((1 << NARROW_W) - 1);

  logic [WORD_W-1:0] rest_q;
  logic [CNT_W-1:0]  left_q;
  logic [GRP_W-1:0]  mask;

  assign mask = width8_sel ? '1 : NARROW_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      rest_q    <= '0;
      left_q    <= '0;
      pix_out   <= '0;
      pix_valid <= 1'b0;
    end else if (load_stb) begin
      pix_out   <= word[GRP_W-1:0] & mask;
      rest_q    <= word >> GRP_W;
      left_q    <= grp_count - CNT_W'(1);
      pix_valid <= 1'b1;
    end else if (left_q != '0) begin
      pix_out   <= rest_q[GRP_W-1:0] & mask;
      rest_q    <= rest_q >> GRP_W;
      left_q    <= left_q - CNT_W'(1);
      pix_valid <= 1'b1;
    end else begin
      pix_out   <= '0;
      pix_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pix_unpack_mux.sv
module pix_unpack_mux #(
  parameter int GRP_W    = 8,
  parameter int GROUPS   = 2,
  parameter int NARROW_W = 6,
  parameter int CFG_W    = 8,
  localparam int WORD_W  = GRP_W * GROUPS,
  localparam int CNT_W   = $clog2(GROUPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] pix_bus,
  input  logic [GRP_W-1:0]  vga_bus,
  input  logic              width8_sel,
  output logic [GRP_W-1:0]  pix_out,
  output logic              pix_valid
);

  logic [5:0]        mode_code;
  logic [CNT_W-1:0]  grp_count;
  logic [WORD_W-1:0] word;

  pix_cfg_regs #(.GROUPS(GROUPS), .CFG_W(CFG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mode_code (mode_code),
    .grp_count (grp_count)
  );

  pix_src_select #(.GRP_W(GRP_W), .GROUPS(GROUPS)) u_sel (
    .mode_code (mode_code),
    .pix_bus   (pix_bus),
    .vga_bus   (vga_bus),
    .word      (word)
  );

  pix_shift_unit #(.GRP_W(GRP_W), .GROUPS(GROUPS), .NARROW_W(NARROW_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_stb   (load_stb),
    .word       (word),
    .grp_count  (grp_count),
    .width8_sel (width8_sel),
    .pix_out    (pix_out),
    .pix_valid  (pix_valid)
  );

endmodule

// File: rtl/pix_unpack_mux_chk.sv
module pix_unpack_mux_chk #(
  parameter int GRP_W    = 8,
  parameter int GROUPS   = 2,
  parameter int NARROW_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             load_stb,
  input logic             width8_sel,
  input logic [GRP_W-1:0] pix_out,
  input logic             pix_valid
);

  logic [3:0] since_load;

  always_ff @(posedge clk) begin
    if (rst) since_load <= 4'hF;
    else if (load_stb) since_load <= 4'd1;
    else if (since_load != 4'hF) since_load <= since_load + 4'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!pix_valid && pix_out == '0));

  p_load_valid_r6: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> pix_valid);

  p_burst_bound_r6: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (int'(since_load) <= GROUPS));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !pix_valid) |=> !pix_valid);

  p_zero_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> pix_out == '0);

  p_narrow_top_r8: assert property (@(posedge clk) disable iff (rst)
    !width8_sel |=> pix_out[GRP_W-1:NARROW_W] == '0);

endmodule

bind pix_unpack_mux pix_unpack_mux_chk #(
  .GRP_W(GRP_W), .GROUPS(GROUPS), .NARROW_W(NARROW_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_stb   (load_stb),
  .width8_sel (width8_sel),
  .pix_out    (pix_out),
  .pix_valid  (pix_valid)
);

// File: tb/pix_unpack_mux_bench.sv
module pix_unpack_mux_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [7:0]  mode;
    logic [7:0]  ratio;
    logic        w8;
    logic [15:0] pix;
    logic [7:0]  vga;
    logic [1:0]  n;
    logic [7:0]  e0;
    logic [7:0]  e1;
  } vec_t;

  localparam int NVEC = 10;
  localparam logic [58:0] VEC [NVEC] = '{
    {8'h2D, 8'd1, 1'b1, 16'h1234, 8'hA5, 2'd1, 8'hA5, 8'h00}, // R2 pass-through
    {8'h2D, 8'd1, 1'b0, 16'h1234, 8'hA5, 2'd1, 8'h25, 8'h00}, // R8 narrow
    {8'h1C, 8'd1, 1'b1, 16'hBEEF, 8'h11, 2'd1, 8'hEF, 8'h00}, // R3 single
    {8'h1D, 8'd2, 1'b1, 16'hBEEF, 8'h11, 2'd2, 8'hEF, 8'hBE}, // R4 two-pixel order
    {8'h9D, 8'd2, 1'b1, 16'hC35A, 8'h11, 2'd2, 8'h5A, 8'hC3}, // R2 top bits ignored
    {8'h1D, 8'd2, 1'b0, 16'hFFFF, 8'h11, 2'd2, 8'h3F, 8'h3F}, // R8 narrow both groups
    {8'h3F, 8'd1, 1'b1, 16'h1234, 8'h77, 2'd1, 8'h77, 8'h00}, // R9 undefined mode
    {8'h2D, 8'd2, 1'b1, 16'h1234, 8'h81, 2'd2, 8'h81, 8'h00}, // R2 upper group zero
    {8'h1D, 8'd0, 1'b1, 16'hABCD, 8'h11, 2'd1, 8'hCD, 8'h00}, // R5 zero clamps to 1
    {8'h1D, 8'd3, 1'b1, 16'hABCD, 8'h11, 2'd2, 8'hCD, 8'hAB}  // R5 large clamps to 2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        load_stb = 1'b0;
  logic [15:0] pix_bus = '0;
  logic [7:0]  vga_bus = '0;
  logic        width8_sel = 1'b1;
  logic [7:0]  pix_out;
  logic        pix_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_unpack_mux u_pix_unpack_mux (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .load_stb   (load_stb),
    .pix_bus    (pix_bus),
    .vga_bus    (vga_bus),
    .width8_sel (width8_sel),
    .pix_out    (pix_out),
    .pix_valid  (pix_valid)
  );

  task automatic check(input string req, input logic ev, input logic [7:0] eo);
    checks++;
    if (pix_valid !== ev || pix_out !== eo) begin
      failures++;
      $display("FAIL %s valid=%0b out=%02h expected valid=%0b out=%02h",
               req, pix_valid, pix_out, ev, eo);
    end
  endtask

  task automatic cfg_write(input logic addr, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] p, input logic [7:0] v);
    @(negedge clk);
    pix_bus = p; vga_bus = v; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset outputs", 1'b0, 8'h00);

    // R1: default pass-through, one group per load
    do_load(16'h1234, 8'h5C);
    check("R1 default source", 1'b1, 8'h5C);
    @(negedge clk);
    check("R1 default count", 1'b0, 8'h00);

    // R10: idle cycles stay quiet
    repeat (3) @(negedge clk);
    check("R10 idle", 1'b0, 8'h00);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VEC[i];
      cfg_write(1'b0, v.mode);
      cfg_write(1'b1, v.ratio);
      width8_sel = v.w8;
      do_load(v.pix, v.vga);
      check($sformatf("vector %0d group0", i), 1'b1, v.e0);
      if (v.n == 2'd2) begin
        @(negedge clk);
        check($sformatf("vector %0d group1", i), 1'b1, v.e1);
      end
      @(negedge clk);
      check($sformatf("R6 vector %0d end of burst", i), 1'b0, 8'h00);
    end
    width8_sel = 1'b1;

    // R5: mode write keeps the count (2); single mode upper group is zero (R3)
    cfg_write(1'b1, 8'd2);
    cfg_write(1'b0, 8'h1C);
    do_load(16'h4477, 8'h00);
    check("R5 count kept g0", 1'b1, 8'h77);
    @(negedge clk);
    check("R5 count kept g1 R3 zero", 1'b1, 8'h00);
    @(negedge clk);
    check("R5 burst end", 1'b0, 8'h00);

    // R7: reload during a pending group
    cfg_write(1'b0, 8'h1D);
    do_load(16'h1122, 8'h00);
    check("R7 first word g0", 1'b1, 8'h22);
    pix_bus = 16'h3344; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
    check("R7 restart g0", 1'b1, 8'h44);
    @(negedge clk);
    check("R7 restart g1", 1'b1, 8'h33);
    @(negedge clk);
    check("R7 no stale group", 1'b0, 8'h00);

    // R8: width select sampled per group
    do_load(16'hFFFF, 8'h00);
    check("R8 wide group", 1'b1, 8'hFF);
    width8_sel = 1'b0;
    @(negedge clk);
    check("R8 narrow group", 1'b1, 8'h3F);
    width8_sel = 1'b1;
    @(negedge clk);

    // R11: configuration write and load in one cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h2D;
    load_stb = 1'b1; pix_bus = 16'hBEEF; vga_bus = 8'h99;
    @(negedge clk);
    cfg_we = 1'b0; load_stb = 1'b0;
    check("R11 old mode g0", 1'b1, 8'hEF);
    @(negedge clk);
    check("R11 old mode g1", 1'b1, 8'hBE);
    do_load(16'hBEEF, 8'h99);
    check("R11 new mode applied", 1'b1, 8'h99);
    @(negedge clk);
    check("R11 new mode upper zero", 1'b1, 8'h00);

    // R1: reset mid-burst restores defaults
    cfg_write(1'b0, 8'h1D);
    do_load(16'hABCD, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid burst", 1'b0, 8'h00);
    rst = 1'b0;
    do_load(16'h1234, 8'h66);
    check("R1 mode restored", 1'b1, 8'h66);
    @(negedge clk);
    check("R1 count restored", 1'b0, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule